// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command and address pins of a single-rank, four-bank synchronous DRAM from the end of reset until the memory can take normal traffic. First it waits for a programmable number of clock cycles and drives only no-operation commands. It then closes every bank with one precharge-all command. Next it issues a fixed number of auto-refresh commands, two by default, and waits the refresh cycle time after each one. Last, it writes the mode register with a value built from configuration inputs.

Every command and address value holds for one full clock cycle, so the memory samples it on a rising edge. No-operation commands fill every cycle between commands. All wait lengths are parameters counted in clock cycles, and each must be at least 2. After the mode-register delay has run out, `init_done` goes high and stays high until the next reset. The downstream controller uses this flag to take over the bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and for PWRUP_CYC cycles after it is released, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), address and bank are zero, and init_done is low.
- R2: The first command other than NOP is PRECHARGE (0010). It appears exactly PWRUP_CYC cycles after reset release, with address bit 10 high, every other address bit zero and bank zero.
- R3: Exactly NUM_REF AUTO REFRESH commands (0001) are issued, with address and bank zero. The first comes TRP_CYC cycles after the precharge, and each later one comes TRC_CYC cycles after the one before.
- R4: LOAD MODE (0000) is issued TRC_CYC cycles after the last refresh, with bank zero. Its address carries burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, operating mode in bits 8:7 and write-burst mode in bit 9. All higher bits are zero.
- R5: Every cycle that is not one of the commands in R2 to R4 drives NOP with zero address and bank. No two commands are ever adjacent.
- R6: init_done rises exactly TMRD_CYC cycles after LOAD MODE and then stays high, with NOP on the bus, until reset.
- R7: Asserting reset at any point returns the block to the R1 behaviour, and the whole sequence restarts when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output changes after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Burst-length code for the mode register |
| cfg_burst_type | input | 1 | Burst-type bit for the mode register |
| cfg_cas_lat | input | 3 | CAS-latency code for the mode register |
| cfg_op_mode | input | 2 | Operating-mode code for the mode register |
| cfg_wr_burst | input | 1 | Write-burst-mode bit for the mode register |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
Each fault in the phase state or in the wait counter appears on the command pins, one cycle off or as the wrong command, in the same cycle where the expected trace departs from the correct one. A refresh counter that is off by one gives a missing or extra auto-refresh in place of LOAD MODE at a fixed cycle. A misplaced mode field gives a wrong address in the single LOAD MODE cycle. The bench checks every cycle of each run against a timeline computed from the parameters. It repeats this across many configuration words and adds one reset in the middle of the sequence, so each of these faults is caught in the first cycle where it shows.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PWRUP_CYC = 20000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 9,
  parameter int TMRD_CYC  = 2,
  parameter int NUM_REF   = 2,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [1:0]        cfg_op_mode,
  input  logic              cfg_wr_burst,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int MAX_A = (PWRUP_CYC > TRC_CYC) ? PWRUP_CYC : TRC_CYC;
  localparam int MAX_B = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int REF_W = $clog2(NUM_REF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [2:0] {
    PH_PWR, PH_PRE, PH_WRP, PH_REF, PH_WRC, PH_LMR, PH_WMRD, PH_DONE
  } phase_t;

  phase_t             ph;
  logic [CNT_W-1:0]   cnt;
  logic [REF_W-1:0]   refs;
  logic [3:0]         cmd;
  logic               cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_PWR;
      cnt  <= CNT_W'(PWRUP_CYC - 1);
      refs <= '0;
    end else begin
      case (ph)
        PH_PWR:  if (cnt_zero) ph <= PH_PRE; else cnt <= cnt - 1'b1;
        PH_PRE: begin
          ph  <= PH_WRP;
          cnt <= CNT_W'(TRP_CYC - 2);
        end
        PH_WRP:  if (cnt_zero) ph <= PH_REF; else cnt <= cnt - 1'b1;
        PH_REF: begin
          ph   <= PH_WRC;
          cnt  <= CNT_W'(TRC_CYC - 2);
          refs <= refs + 1'b1;
        end
        PH_WRC: begin
          if (cnt_zero) ph <= (refs == REF_W'(NUM_REF)) ? PH_LMR : PH_REF;
          else          cnt <= cnt - 1'b1;
        end
        PH_LMR: begin
          ph  <= PH_WMRD;
          cnt <= CNT_W'(TMRD_CYC - 2);
        end
        PH_WMRD: if (cnt_zero) ph <= PH_DONE; else cnt <= cnt - 1'b1;
        default: ph <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_addr = '0;
    case (ph)
      PH_PRE: begin
        cmd         = C_PRE;
        sd_addr[10] = 1'b1;
      end
      PH_REF: cmd = C_REF;
      PH_LMR: begin
        cmd          = C_LMR;
        sd_addr[9:0] = {cfg_wr_burst, cfg_op_mode, cfg_cas_lat, cfg_burst_type, cfg_burst_len};
      end
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba     = '0;
  assign init_done = (ph == PH_DONE);

  assert_cmd_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_NOP) || (cmd == C_PRE) || (cmd == C_REF) || (cmd == C_LMR));

  assert_cmd_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP) |=> (cmd == C_NOP));

  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (sd_addr[10] && $past(ph) == PH_PWR));

  assert_lmr_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> (refs == REF_W'(NUM_REF)));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == C_NOP && sd_addr == '0));

  assert_refs_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refs <= REF_W'(NUM_REF));

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int PW = 10, RP = 3, RC = 4, MRD = 2, NR = 2;
  localparam int T_PRE = PW;
  localparam int T_LMR = PW + RP + NR * RC;
  localparam int T_DONE = T_LMR + MRD;

  logic clk = 0, rst_n = 0;
  logic [9:0] cfg = '0;
  logic cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [11:0] addr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.PWRUP_CYC(PW), .TRP_CYC(RP), .TRC_CYC(RC), .TMRD_CYC(MRD),
                   .NUM_REF(NR), .ADDR_W(12), .BA_W(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_len(cfg[2:0]), .cfg_burst_type(cfg[3]), .cfg_cas_lat(cfg[6:4]),
    .cfg_op_mode(cfg[8:7]), .cfg_wr_burst(cfg[9]),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .init_done(done));

  task automatic check(string req, logic [3:0] ecmd, logic [11:0] eaddr, logic edone);
    logic [3:0] acmd;
    acmd = {cs_n, ras_n, cas_n, we_n};
    checks++;
    if (acmd !== ecmd || addr !== eaddr || ba !== 2'b00 || done !== edone) begin
      fails++;
      $display("FAIL %s t=%0t cmd/addr/ba/done actual=%b/%h/%b/%b expected=%b/%h/00/%b",
               req, $time, acmd, addr, ba, done, ecmd, eaddr, edone);
    end
  endtask

  task automatic expect_at(int i);
    logic [11:0] mode;
    int bl, bt, cl, op, wb;
    bl = cfg % 8; bt = (cfg / 8) % 2; cl = (cfg / 16) % 8; op = (cfg / 128) % 4; wb = cfg / 512;
    mode = 12'(bl + bt * 8 + cl * 16 + op * 128 + wb * 512);
    if (i < T_PRE)                check("R1", 4'b0111, 12'h000, 1'b0);
    else if (i == T_PRE)          check("R2", 4'b0010, 12'h400, 1'b0);
    else if (i > T_PRE && i < T_LMR && ((i - T_PRE - RP) % RC == 0) && i >= T_PRE + RP)
                                  check("R3", 4'b0001, 12'h000, 1'b0);
    else if (i == T_LMR)          check("R4", 4'b0000, mode, 1'b0);
    else if (i >= T_DONE)         check("R6", 4'b0111, 12'h000, 1'b1);
    else                          check("R5", 4'b0111, 12'h000, 1'b0);
  endtask

  task automatic run(int ncyc, int abort_at);
    rst_n = 0;
    repeat (3) begin
      @(negedge clk); #1;
      check("R7", 4'b0111, 12'h000, 1'b0);
    end
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < ncyc; i++) begin
      #1;
      if (i == abort_at) begin
        rst_n = 0;
        @(negedge clk); #1;
        check("R7", 4'b0111, 12'h000, 1'b0);
        return;
      end
      expect_at(i);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      cfg = 10'((k * 37 + k / 8) % 1024);
      run(T_DONE + 6, -1);
    end
    cfg = 10'h3ff; run(T_DONE + 6, -1);
    cfg = 10'h2a5; run(T_DONE + 6, T_PRE + RP + 2);
    cfg = 10'h15a; run(T_DONE + 40, -1);
    cfg = 10'h0f0; run(T_DONE + 2, T_DONE + 1);
    cfg = 10'h001; run(T_DONE + 4, -1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule